// File: doc/BRIEF.md
# Latched Microsecond Timebase

This block keeps a 64-bit count of microseconds that starts at zero when reset is released. The count moves forward by one on each cycle in which the one-cycle tick input is high. Software reaches the count through a 32-bit register port in the style of APB, which works in two phases (select, then enable). Because the count is wider than the data bus, both reads and writes are split into halves.

A write to the low word is held in a staging register. A later write to the high word loads the whole 64-bit value in one cycle. A read of the low word copies the high half into a shadow register at that moment, so that the following high-word read returns a value that matches it. Two raw read addresses return the live halves and change no internal state.

The count can be held still in two ways: by a software pause bit, or by a debug-active input from either of two cores while that core's enable bit is set. The low 32 bits of the live count are driven out on every cycle, for the alarm comparators.

Top module: `usec_timebase`

## Requirements
- R1: After reset the count is zero, the pause bit (offset 0x30, bit 0) reads 0, and the debug-hold register (offset 0x2C) reads 0x6.
- R2: Each cycle with `tickIn` high and no hold in force adds one to the 64-bit count, with carry from bit 31 into bit 32. Without a tick the count does not change.
- R3: A write to offset 0x04 only loads the staging register and leaves the count unchanged. A write to offset 0x00 sets the count to {write data, staging value} in one cycle.
- R4: When a write to offset 0x00 falls in the same cycle as a tick, the loaded value is kept and that tick is lost.
- R5: A read of offset 0x0C returns the live low half and captures the live high half. A later read of offset 0x08 returns the captured value, even if the count has carried into the high half in between.
- R6: Reads of offset 0x24 (raw high) and offset 0x28 (raw low) return the live count and change neither the captured high half nor the staging register.
- R7: While the pause bit is 1, ticks do not advance the count. Clearing the bit lets counting resume from the held value.
- R8: Offset 0x2C bit 1 enables holding for core 0 and bit 2 enables holding for core 1. The count is held while a core's enable bit is 1 and its `dbgActiveIn` bit is high. A core whose enable bit is 0 has no effect on the count.
- R9: Undefined or unaligned offsets read as zero, and writes to them have no effect. Register bits that are not defined read as zero.
- R10: `countLowOut` equals the low 32 bits of the live count on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickIn | input | 1 | One-cycle microsecond tick |
| dbgActiveIn | input | 2 | Debug-active flag, one bit per core |
| pselIn | input | 1 | Register port select |
| penableIn | input | 1 | Register port access phase |
| pwriteIn | input | 1 | 1 for a write, 0 for a read |
| paddrIn | input | 8 | Byte offset |
| pwdataIn | input | 32 | Write data |
| prdataOut | output | 32 | Read data, valid while selected for a read |
| countLowOut | output | 32 | Low word of the live count |

## Verification
The assertions check on every cycle that the count steps by exactly one on an allowed tick and holds otherwise. They also check that a high-word write loads {data, staging} even when a tick lands in the same cycle, that raw reads leave the shadow and staging registers alone, that an enabled debug hold blocks any advance, and that at most one register strobe fires in a cycle. The bench scenarios cover the effects that depend on order: the low-then-high read pair across a carry into the high half, staging that survives other accesses, read values of the pause and debug-hold registers, and the zeros returned for undefined offsets. A reference model follows randomly mixed ticks, holds and accesses.

// File: rtl/timebase_pkg.sv
package timebase_pkg;
  // Byte offsets decoded by the register port
  localparam int unsigned OfsWrHigh  = 'h00;
  localparam int unsigned OfsWrLow   = 'h04;
  localparam int unsigned OfsRdHigh  = 'h08;
  localparam int unsigned OfsRdLow   = 'h0C;
  localparam int unsigned OfsRawHigh = 'h24;
  localparam int unsigned OfsRawLow  = 'h28;
  localparam int unsigned OfsDbgHold = 'h2C;
  localparam int unsigned OfsPause   = 'h30;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SHADOW_HIGH, SEL_LIVE_LOW, SEL_RAW_HIGH,
    SEL_RAW_LOW, SEL_DBG_HOLD, SEL_PAUSE
  } readSelT;

  typedef struct packed {
    logic loadCount;  // apply {data, staging} to the count
    logic stageLow;   // capture data into staging
    logic latchHigh;  // capture live high half into shadow
  } strobeT;
endpackage

// File: rtl/timebase_ctrl.sv
module timebase_ctrl
  import timebase_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_CORES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickIn,
  input  logic [NUM_CORES-1:0] dbgActiveIn,
  input  logic                 pselIn,
  input  logic                 penableIn,
  input  logic                 pwriteIn,
  input  logic [ADDR_W-1:0]    paddrIn,
  input  logic [NUM_CORES:0]   wdataBits,
  output strobeT               strobes,
  output logic                 advanceEn,
  output readSelT              readSel,
  output logic                 pauseBit,
  output logic [NUM_CORES-1:0] dbgHoldEn
);
  logic wrAccess, rdAccess, frozen;

  assign wrAccess = pselIn && penableIn && pwriteIn;
  assign rdAccess = pselIn && penableIn && !pwriteIn;

  always_comb begin
    strobes.loadCount = wrAccess && (paddrIn == ADDR_W'(OfsWrHigh));
    strobes.stageLow  = wrAccess && (paddrIn == ADDR_W'(OfsWrLow));
    strobes.latchHigh = rdAccess && (paddrIn == ADDR_W'(OfsRdLow));
  end

  always_comb begin
    readSel = SEL_NONE;
    if (pselIn && !pwriteIn) begin
      case (paddrIn)
        ADDR_W'(OfsRdHigh):  readSel = SEL_SHADOW_HIGH;
        ADDR_W'(OfsRdLow):   readSel = SEL_LIVE_LOW;
        ADDR_W'(OfsRawHigh): readSel = SEL_RAW_HIGH;
        ADDR_W'(OfsRawLow):  readSel = SEL_RAW_LOW;
        ADDR_W'(OfsDbgHold): readSel = SEL_DBG_HOLD;
        ADDR_W'(OfsPause):   readSel = SEL_PAUSE;
        default:             readSel = SEL_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pauseBit  <= 1'b0;
      dbgHoldEn <= '1;
    end else begin
      if (wrAccess && (paddrIn == ADDR_W'(OfsPause)))   pauseBit  <= wdataBits[0];
      if (wrAccess && (paddrIn == ADDR_W'(OfsDbgHold))) dbgHoldEn <= wdataBits[NUM_CORES:1];
    end
  end

  assign frozen    = pauseBit || (|(dbgHoldEn & dbgActiveIn));
  assign advanceEn = tickIn && !frozen;

  // R8: an enabled core in debug blocks any advance
  p_dbg_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|(dbgHoldEn & dbgActiveIn)) |-> !advanceEn);
  // R9: decoded strobes are mutually exclusive
  p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadCount, strobes.stageLow, strobes.latchHigh}));
endmodule

// File: rtl/timebase_datapath.sv
module timebase_datapath
  import timebase_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_CORES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               strobes,
  input  logic                 advanceEn,
  input  readSelT              readSel,
  input  logic                 pauseBit,
  input  logic [NUM_CORES-1:0] dbgHoldEn,
  input  logic [DATA_W-1:0]    wdataIn,
  output logic [DATA_W-1:0]    rdataOut,
  output logic [DATA_W-1:0]    countLowOut
);
  localparam int COUNT_W = 2 * DATA_W;

  logic [COUNT_W-1:0] count;
  logic [DATA_W-1:0]  stageReg;
  logic [DATA_W-1:0]  shadowHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count      <= '0;
      stageReg   <= '0;
      shadowHigh <= '0;
    end else begin
      if (strobes.loadCount)  count <= {wdataIn, stageReg};
      else if (advanceEn)     count <= count + COUNT_W'(1);
      if (strobes.stageLow)   stageReg   <= wdataIn;
      if (strobes.latchHigh)  shadowHigh <= count[COUNT_W-1:DATA_W];
    end
  end

  always_comb begin
    case (readSel)
      SEL_SHADOW_HIGH: rdataOut = shadowHigh;
      SEL_LIVE_LOW:    rdataOut = count[DATA_W-1:0];
      SEL_RAW_HIGH:    rdataOut = count[COUNT_W-1:DATA_W];
      SEL_RAW_LOW:     rdataOut = count[DATA_W-1:0];
      SEL_DBG_HOLD:    rdataOut = {{(DATA_W-NUM_CORES-1){1'b0}}, dbgHoldEn, 1'b0};
      SEL_PAUSE:       rdataOut = {{(DATA_W-1){1'b0}}, pauseBit};
      default:         rdataOut = '0;
    endcase
  end

  assign countLowOut = count[DATA_W-1:0];

  // R2: an allowed tick steps the count by exactly one
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (advanceEn && !strobes.loadCount) |=> count == $past(count) + COUNT_W'(1));
  // R7: with no tick allowed and no load the count holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!advanceEn && !strobes.loadCount) |=> $stable(count));
  // R3, R4: high write loads {data, staging} whatever the tick does
  p_load_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCount |=> count == {$past(wdataIn), $past(stageReg)});
  // R6: raw reads leave shadow and staging alone
  p_raw_clean_r6: assert property (@(posedge clk) disable iff (!rstN)
    (readSel == SEL_RAW_HIGH || readSel == SEL_RAW_LOW) |=>
      ($stable(shadowHigh) && $stable(stageReg)));
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
  import timebase_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_CORES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickIn,
  input  logic [NUM_CORES-1:0] dbgActiveIn,
  input  logic                 pselIn,
  input  logic                 penableIn,
  input  logic                 pwriteIn,
  input  logic [ADDR_W-1:0]    paddrIn,
  input  logic [DATA_W-1:0]    pwdataIn,
  output logic [DATA_W-1:0]    prdataOut,
  output logic [DATA_W-1:0]    countLowOut
);
  strobeT                 strobes;
  logic                   advanceEn;
  readSelT                readSel;
  logic                   pauseBit;
  logic [NUM_CORES-1:0]   dbgHoldEn;

  timebase_ctrl #(.ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES)) i_ctrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .dbgActiveIn(dbgActiveIn),
    .pselIn(pselIn), .penableIn(penableIn), .pwriteIn(pwriteIn),
    .paddrIn(paddrIn), .wdataBits(pwdataIn[NUM_CORES:0]),
    .strobes(strobes), .advanceEn(advanceEn), .readSel(readSel),
    .pauseBit(pauseBit), .dbgHoldEn(dbgHoldEn)
  );

  timebase_datapath #(.DATA_W(DATA_W), .NUM_CORES(NUM_CORES)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .advanceEn(advanceEn),
    .readSel(readSel), .pauseBit(pauseBit), .dbgHoldEn(dbgHoldEn),
    .wdataIn(pwdataIn), .rdataOut(prdataOut), .countLowOut(countLowOut)
  );
endmodule

// File: tb/test_usec_timebase.sv
module test_usec_timebase;
  localparam int ClkPeriod = 10;
  localparam int MaxCycles = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic [1:0]  dbgActiveIn = 2'b00;
  logic        pselIn = 1'b0, penableIn = 1'b0, pwriteIn = 1'b0;
  logic [7:0]  paddrIn = '0;
  logic [31:0] pwdataIn = '0;
  logic [31:0] prdataOut, countLowOut;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  // reference model
  logic [63:0] mCount = '0;
  logic [31:0] mStage = '0, mShadow = '0;
  logic        mPause = 1'b0;
  logic [1:0]  mDbg = 2'b11;

  usec_timebase i_usec_timebase (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .dbgActiveIn(dbgActiveIn),
    .pselIn(pselIn), .penableIn(penableIn), .pwriteIn(pwriteIn),
    .paddrIn(paddrIn), .pwdataIn(pwdataIn), .prdataOut(prdataOut),
    .countLowOut(countLowOut)
  );

  always #(ClkPeriod/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= MaxCycles && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog expired: actual cycles=%0d expected below %0d", cycles, MaxCycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic bit heldBy(logic p, logic [1:0] en, logic [1:0] act);
    return p || ((en & act) != 2'b00);
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic apbWrite(logic [7:0] a, logic [31:0] d, bit withTick = 1'b0);
    @(negedge clk);
    pselIn = 1; pwriteIn = 1; paddrIn = a; pwdataIn = d;
    @(negedge clk);
    penableIn = 1; tickIn = withTick;
    @(negedge clk);
    pselIn = 0; penableIn = 0; pwriteIn = 0; tickIn = 0;
    // model
    if (a == 8'h04) mStage = d;
    else if (a == 8'h00) mCount = {d, mStage};
    else if (a == 8'h30) mPause = d[0];
    else if (a == 8'h2C) mDbg = d[2:1];
  endtask

  task automatic apbRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    pselIn = 1; pwriteIn = 0; paddrIn = a;
    @(negedge clk);
    penableIn = 1;
    #(ClkPeriod/4);
    d = prdataOut;
    @(negedge clk);
    pselIn = 0; penableIn = 0;
    if (a == 8'h0C) mShadow = mCount[63:32];
  endtask

  task automatic doTick(logic [1:0] act);
    @(negedge clk);
    tickIn = 1; dbgActiveIn = act;
    @(negedge clk);
    tickIn = 0; dbgActiveIn = 2'b00;
    if (!heldBy(mPause, mDbg, act)) mCount = mCount + 64'd1;
  endtask

  task automatic checkRaw(string req);
    logic [31:0] hi, lo;
    apbRead(8'h28, lo);
    apbRead(8'h24, hi);
    check(req, {hi, lo}, mCount);
  endtask

  logic [31:0] rv, lo, hi;

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkRaw("R1 count after reset");
    apbRead(8'h30, rv); check("R1 pause reset", rv, 0);
    apbRead(8'h2C, rv); check("R1 debug-hold reset", rv, 32'h6);

    // R2 basic ticks, R10 export
    repeat (5) doTick(2'b00);
    checkRaw("R2 five ticks");
    check("R10 countLowOut", countLowOut, mCount[31:0]);

    // R3 staging then load, R2 carry
    apbWrite(8'h04, 32'hFFFF_FFFE);
    checkRaw("R3 low write only stages");
    apbWrite(8'h00, 32'h0000_0012);
    checkRaw("R3 high write loads both halves");
    repeat (3) doTick(2'b00);
    check("R2 carry into high half", mCount, 64'h13_0000_0001);
    checkRaw("R2 carry live");
    check("R10 countLowOut after carry", countLowOut, 32'h1);

    // R5 coherent pair across a carry
    apbWrite(8'h04, 32'hFFFF_FFFF);
    apbWrite(8'h00, 32'h7);
    apbRead(8'h0C, lo);
    check("R5 live low", lo, 32'hFFFF_FFFF);
    doTick(2'b00);
    apbRead(8'h08, hi);
    check("R5 shadow high after carry", hi, 32'h7);
    // R6 raw reads live and leave shadow
    apbRead(8'h24, rv); check("R6 raw high live", rv, 32'h8);
    apbRead(8'h28, rv);
    apbRead(8'h08, hi); check("R6 shadow untouched by raw", hi, 32'h7);
    apbWrite(8'h04, 32'hABCD_0001);
    apbRead(8'h24, rv); apbRead(8'h28, rv);
    apbWrite(8'h00, 32'h55);
    checkRaw("R6 staging untouched by raw");

    // R4 load with concurrent tick
    apbWrite(8'h04, 32'h100);
    apbWrite(8'h00, 32'h2, 1'b1);
    checkRaw("R4 tick in load cycle dropped");
    check("R4 exact value", mCount, 64'h2_0000_0100);

    // R7 pause
    apbWrite(8'h30, 32'h1);
    repeat (4) doTick(2'b00);
    checkRaw("R7 paused count holds");
    apbWrite(8'h30, 32'h0);
    doTick(2'b00);
    checkRaw("R7 resume");

    // R8 debug holds
    doTick(2'b01); checkRaw("R8 core0 hold");
    doTick(2'b10); checkRaw("R8 core1 hold");
    apbWrite(8'h2C, 32'h4);
    apbRead(8'h2C, rv); check("R8 enable readback", rv, 32'h4);
    doTick(2'b01); checkRaw("R8 core0 disabled has no effect");
    doTick(2'b10); checkRaw("R8 core1 still holds");

    // R9 undefined offsets and unused bits
    apbRead(8'h44, rv); check("R9 undefined offset reads zero", rv, 0);
    apbRead(8'h0D, rv); check("R9 unaligned reads zero", rv, 0);
    apbRead(8'h04, rv); check("R9 write-only offset reads zero", rv, 0);
    apbWrite(8'h10, 32'hDEAD_BEEF);
    apbWrite(8'h0E, 32'hDEAD_BEEF);
    checkRaw("R9 ignored writes leave count");
    apbWrite(8'h30, 32'hFFFF_FFFE);
    apbRead(8'h30, rv); check("R9 pause unused bits", rv, 0);
    apbWrite(8'h2C, 32'hFFFF_FFFF);
    apbRead(8'h2C, rv); check("R9 debug-hold unused bits", rv, 32'h6);

    // random mix against the model
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 7);
      case (op)
        0, 1: doTick(2'($urandom_range(0, 3)));
        2: apbWrite(8'h04, $urandom);
        3: apbWrite(8'h00, (($urandom_range(0, 1) == 1) ? 32'h0 : $urandom), $urandom_range(0, 1) == 1);
        4: begin
          apbRead(8'h0C, lo);
          check("R5 random live low", lo, mCount[31:0]);
          if ($urandom_range(0, 1) == 1) doTick(2'b00);
          apbRead(8'h08, hi);
          check("R5 random shadow high", hi, mShadow);
        end
        5: checkRaw("R6 random raw pair");
        6: apbWrite(8'h30, 32'($urandom_range(0, 1)));
        default: apbWrite(8'h2C, $urandom);
      endcase
      check("R10 random countLowOut", countLowOut, mCount[31:0]);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule